// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block decodes the I/O-mapped register window through which software controls the bus-master DMA of a two-channel disk controller. The window is sixteen bytes long and holds one eight-byte group per channel. Channel 0 starts at offset 0 and channel 1 at offset 8. In each group the low four bytes are a control/status area that only takes single-byte accesses. The high four bytes hold a descriptor pointer that only takes aligned 32-bit accesses.

The control area holds four registers. The first is a command byte, and each write to it is passed to that channel's DMA engine as a one-cycle strobe. The second is an alias of a mode/interrupt register shared by both channels and held in the configuration block. The third is a status byte whose fields each follow their own write rule. The fourth is a per-channel transfer timing byte. The DMA engine drives the status fields for activity, error and interrupt. An access of any other size or alignment reads as all ones for its width and writes nothing.

Top module: `bmw_window`

## Requirements
- R1: After reset the command, status and pointer registers of both channels read 0. Each timing register reads its strap value from the TIM_RST parameter, where byte c belongs to channel c.
- R2: A byte write to group offset 0 (group base = 8 × channel) raises cmd_stb for that channel alone, for exactly the next cycle, and presents the written byte on that channel's 8-bit lane of cmd_byte. A byte read of offset 0 returns the last byte written there.
- R3: A byte read of offset 1 in either group returns mode_in. A byte write there pulses mode_wr in the same cycle, with mode_wdata equal to mode_in with bits 4 and 5 replaced by the written bits 4 and 5.
- R4: A byte write to offset 2 (status) works as follows. Bits 5 and 6 take the written value. Bits 1 and 2 clear where a 1 is written and are otherwise kept. Bits 3, 4 and 7 are always 0.
- R5: Status bit 0 reads eng_active as sampled one cycle earlier. A pulse of eng_err_set or eng_irq_set sets status bit 1 or bit 2 of that channel. A set wins over a clear written in the same cycle.
- R6: Offset 3 is a fully writable per-channel timing byte that reads back what was written.
- R7: In the control area (offsets 0 to 3), a read of size code 1 (16-bit) returns 0x0000FFFF. A read of size code 2 or 3 returns 0xFFFFFFFF. Size code 0 is a byte access, and byte data travels on bits 7:0 with bits 31:8 zero.
- R8: A write of any size code other than 0 to the control area changes no register and raises neither cmd_stb nor mode_wr.
- R9: A 32-bit write (size code 2) at group offset 4 stores the data with bits 1:0 forced to 0, and a 32-bit read there returns the stored value. Any other access at offsets 4 to 7 reads as all ones for its width and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Byte offset within the window |
| io_rd | input | 1 | Read access this cycle |
| io_wr | input | 1 | Write access this cycle |
| io_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| io_wdata | input | 32 | Write data, byte data on bits 7:0 |
| io_rdata | output | 32 | Read data, combinational, zero when io_rd is low |
| cmd_stb | output | 2 | Per-channel command strobe, one cycle |
| cmd_byte | output | 16 | Command byte per channel, 8 bits each |
| mode_in | input | 8 | Current value of the shared mode register |
| mode_wr | output | 1 | Write request to the shared mode register |
| mode_wdata | output | 8 | Merged value for the shared mode register |
| eng_active | input | 2 | Per-channel engine busy flag |
| eng_err_set | input | 2 | Per-channel error set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse |

## Verification
The assertions assume that io_rd and io_wr are never high in the same cycle. They also assume that io_addr and io_size are stable for the whole cycle in which an access is signalled. Engine set pulses may arrive in any cycle, including one with a write. The stimulus changes every input only on the falling clock edge and never raises io_rd and io_wr together. It mixes random offsets, all four size codes and random engine pulses with directed cases for the set-versus-clear race, aligned and misaligned pointer accesses, and the strap reset value.

// File: rtl/bmw_pkg.sv
`timescale 1ns/1ps
package bmw_pkg;
    localparam int unsigned REG_BITS  = 8;
    localparam int unsigned DATA_BITS = 32;
    localparam int unsigned GRP_BYTES = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TIM  = 2'd3
    } ctrl_sel_e;

    localparam int unsigned ST_ACTIVE = 0;
    localparam int unsigned ST_ERR    = 1;
    localparam int unsigned ST_IRQ    = 2;
    localparam logic [REG_BITS-1:0] ST_PLAIN_MASK = 8'h60;
    localparam logic [REG_BITS-1:0] MODE_WR_MASK  = 8'h30;

    typedef struct packed {
        logic [REG_BITS-1:0]  stat;
        logic [REG_BITS-1:0]  tim;
        logic [DATA_BITS-1:0] ptr;
        logic [REG_BITS-1:0]  cmd;
        logic                 cmd_stb;
    } chan_state_t;

    function automatic logic [DATA_BITS-1:0] size_ones(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_ones = 32'h0000_00FF;
            SZ_HALF: size_ones = 32'h0000_FFFF;
            default: size_ones = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/bmw_decode.sv
`timescale 1ns/1ps
module bmw_decode
    import bmw_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = $clog2(NUM_CH * GRP_BYTES)
) (
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_wr,
    input  logic [1:0]              io_size,
    output logic [ADDR_W-4:0]       grp,
    output logic [1:0]              sel,
    output logic                    ctrl_byte,
    output logic                    ptr_word,
    output logic                    wr_mode,
    output logic [NUM_CH-1:0]       wr_cmd,
    output logic [NUM_CH-1:0]       wr_stat,
    output logic [NUM_CH-1:0]       wr_tim,
    output logic [NUM_CH-1:0]       wr_ptr
);
    localparam int unsigned GRP_W = ADDR_W - 3;

    logic [2:0] off;

    always_comb begin
        grp       = io_addr[ADDR_W-1:3];
        off       = io_addr[2:0];
        sel       = off[1:0];
        ctrl_byte = !off[2] && (io_size == SZ_BYTE);
        ptr_word  = (off == 3'd4) && (io_size == SZ_WORD);
        wr_mode   = io_wr && ctrl_byte && (sel == SEL_MODE);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        logic hit;
        assign hit        = io_wr && (grp == GRP_W'(c));
        assign wr_cmd[c]  = hit && ctrl_byte && (sel == SEL_CMD);
        assign wr_stat[c] = hit && ctrl_byte && (sel == SEL_STAT);
        assign wr_tim[c]  = hit && ctrl_byte && (sel == SEL_TIM);
        assign wr_ptr[c]  = hit && ptr_word;
    end
endmodule

// File: rtl/bmw_chan.sv
`timescale 1ns/1ps
module bmw_chan
    import bmw_pkg::*;
#(
    parameter logic [REG_BITS-1:0] TIM_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_cmd,
    input  logic                 wr_stat,
    input  logic                 wr_tim,
    input  logic                 wr_ptr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 eng_active,
    input  logic                 eng_err_set,
    input  logic                 eng_irq_set,
    output logic                 cmd_stb,
    output logic [REG_BITS-1:0]  cmd,
    output logic [REG_BITS-1:0]  stat,
    output logic [REG_BITS-1:0]  tim,
    output logic [DATA_BITS-1:0] ptr
);
    chan_state_t st_d, st_q;
    logic [REG_BITS-1:0] clr_d;

    always_comb begin
        st_d         = st_q;
        clr_d        = wr_stat ? wdata[REG_BITS-1:0] : '0;
        st_d.cmd_stb = wr_cmd;
        if (wr_cmd) begin
            st_d.cmd = wdata[REG_BITS-1:0];
        end
        st_d.stat            = '0;
        st_d.stat[ST_ACTIVE] = eng_active;
        st_d.stat[ST_ERR]    = eng_err_set || (st_q.stat[ST_ERR] && !clr_d[ST_ERR]);
        st_d.stat[ST_IRQ]    = eng_irq_set || (st_q.stat[ST_IRQ] && !clr_d[ST_IRQ]);
        st_d.stat            = st_d.stat | ((wr_stat ? wdata[REG_BITS-1:0] : st_q.stat)
                                            & ST_PLAIN_MASK);
        if (wr_tim) begin
            st_d.tim = wdata[REG_BITS-1:0];
        end
        if (wr_ptr) begin
            st_d.ptr = {wdata[DATA_BITS-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tim <= TIM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_stb = st_q.cmd_stb;
    assign cmd     = st_q.cmd;
    assign stat    = st_q.stat;
    assign tim     = st_q.tim;
    assign ptr     = st_q.ptr;
endmodule

// File: rtl/bmw_rdmux.sv
`timescale 1ns/1ps
module bmw_rdmux
    import bmw_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned GRP_W  = 1
) (
    input  logic                 io_rd,
    input  logic [1:0]           io_size,
    input  logic [GRP_W-1:0]     grp,
    input  logic [1:0]           sel,
    input  logic                 ctrl_byte,
    input  logic                 ptr_word,
    input  logic [REG_BITS-1:0]  mode_in,
    input  logic [REG_BITS-1:0]  cmd_arr  [NUM_CH],
    input  logic [REG_BITS-1:0]  stat_arr [NUM_CH],
    input  logic [REG_BITS-1:0]  tim_arr  [NUM_CH],
    input  logic [DATA_BITS-1:0] ptr_arr  [NUM_CH],
    output logic [DATA_BITS-1:0] io_rdata
);
    logic [REG_BITS-1:0] byte_val;

    always_comb begin
        case (sel)
            SEL_CMD:  byte_val = cmd_arr[grp];
            SEL_MODE: byte_val = mode_in;
            SEL_STAT: byte_val = stat_arr[grp];
            default:  byte_val = tim_arr[grp];
        endcase
        if (!io_rd) begin
            io_rdata = '0;
        end else if (ctrl_byte) begin
            io_rdata = {{(DATA_BITS-REG_BITS){1'b0}}, byte_val};
        end else if (ptr_word) begin
            io_rdata = ptr_arr[grp];
        end else begin
            io_rdata = size_ones(io_size);
        end
    end
endmodule

// File: rtl/bmw_window.sv
`timescale 1ns/1ps
module bmw_window
    import bmw_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter logic [NUM_CH*REG_BITS-1:0] TIM_RST = '0,
    localparam int unsigned ADDR_W = $clog2(NUM_CH * GRP_BYTES),
    localparam int unsigned GRP_W  = ADDR_W - 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          io_addr,
    input  logic                       io_rd,
    input  logic                       io_wr,
    input  logic [1:0]                 io_size,
    input  logic [DATA_BITS-1:0]       io_wdata,
    output logic [DATA_BITS-1:0]       io_rdata,
    output logic [NUM_CH-1:0]          cmd_stb,
    output logic [NUM_CH*REG_BITS-1:0] cmd_byte,
    input  logic [REG_BITS-1:0]        mode_in,
    output logic                       mode_wr,
    output logic [REG_BITS-1:0]        mode_wdata,
    input  logic [NUM_CH-1:0]          eng_active,
    input  logic [NUM_CH-1:0]          eng_err_set,
    input  logic [NUM_CH-1:0]          eng_irq_set
);
    logic [GRP_W-1:0]     grp;
    logic [1:0]           sel;
    logic                 ctrl_byte, ptr_word;
    logic [NUM_CH-1:0]    wr_cmd, wr_stat, wr_tim, wr_ptr;
    logic [REG_BITS-1:0]  cmd_arr  [NUM_CH];
    logic [REG_BITS-1:0]  stat_arr [NUM_CH];
    logic [REG_BITS-1:0]  tim_arr  [NUM_CH];
    logic [DATA_BITS-1:0] ptr_arr  [NUM_CH];

    bmw_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_decode (
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_size   (io_size),
        .grp       (grp),
        .sel       (sel),
        .ctrl_byte (ctrl_byte),
        .ptr_word  (ptr_word),
        .wr_mode   (mode_wr),
        .wr_cmd    (wr_cmd),
        .wr_stat   (wr_stat),
        .wr_tim    (wr_tim),
        .wr_ptr    (wr_ptr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bmw_chan #(.TIM_RST(TIM_RST[c*REG_BITS +: REG_BITS])) i_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_cmd      (wr_cmd[c]),
            .wr_stat     (wr_stat[c]),
            .wr_tim      (wr_tim[c]),
            .wr_ptr      (wr_ptr[c]),
            .wdata       (io_wdata),
            .eng_active  (eng_active[c]),
            .eng_err_set (eng_err_set[c]),
            .eng_irq_set (eng_irq_set[c]),
            .cmd_stb     (cmd_stb[c]),
            .cmd         (cmd_arr[c]),
            .stat        (stat_arr[c]),
            .tim         (tim_arr[c]),
            .ptr         (ptr_arr[c])
        );
        assign cmd_byte[c*REG_BITS +: REG_BITS] = cmd_arr[c];
    end

    assign mode_wdata = (mode_in & ~MODE_WR_MASK) | (io_wdata[REG_BITS-1:0] & MODE_WR_MASK);

    bmw_rdmux #(.NUM_CH(NUM_CH), .GRP_W(GRP_W)) i_rdmux (
        .io_rd     (io_rd),
        .io_size   (io_size),
        .grp       (grp),
        .sel       (sel),
        .ctrl_byte (ctrl_byte),
        .ptr_word  (ptr_word),
        .mode_in   (mode_in),
        .cmd_arr   (cmd_arr),
        .stat_arr  (stat_arr),
        .tim_arr   (tim_arr),
        .ptr_arr   (ptr_arr),
        .io_rdata  (io_rdata)
    );
endmodule

// File: rtl/bmw_window_chk.sv
`timescale 1ns/1ps
module bmw_window_chk
    import bmw_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [1:0]           io_size,
    input logic [DATA_BITS-1:0] io_rdata,
    input logic [NUM_CH-1:0]    cmd_stb,
    input logic                 mode_wr,
    input logic [NUM_CH-1:0]    eng_err_set,
    input logic [NUM_CH-1:0]    eng_irq_set,
    input logic [REG_BITS-1:0]  stat_arr [NUM_CH],
    input logic [REG_BITS-1:0]  tim_arr  [NUM_CH],
    input logic [DATA_BITS-1:0] ptr_arr  [NUM_CH]
);
    p_wide_read_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_size != SZ_BYTE && !io_addr[2]) |-> io_rdata == size_ones(io_size));

    p_wide_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_size != SZ_BYTE) |-> !mode_wr);

    p_cmd_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_size == SZ_BYTE && io_addr[2:0] == 3'd0) |=> $countones(cmd_stb) == 1);

    p_cmd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> cmd_stb == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        p_err_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_err_set[c] |=> stat_arr[c][ST_ERR]);
        p_irq_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_irq_set[c] |=> stat_arr[c][ST_IRQ]);
        p_stat_zero_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_arr[c] & 8'h98) == 8'h00);
        p_ptr_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ptr_arr[c][1:0] == 2'b00);
        p_wide_write_keeps_tim_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (io_wr && io_size != SZ_BYTE) |=> $stable(tim_arr[c]));
    end
endmodule

bind bmw_window bmw_window_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_size     (io_size),
    .io_rdata    (io_rdata),
    .cmd_stb     (cmd_stb),
    .mode_wr     (mode_wr),
    .eng_err_set (eng_err_set),
    .eng_irq_set (eng_irq_set),
    .stat_arr    (stat_arr),
    .tim_arr     (tim_arr),
    .ptr_arr     (ptr_arr)
);

// File: tb/test_bmw_window.sv
`timescale 1ns/1ps
module test_bmw_window;
    localparam logic [15:0] STRAP = 16'h3C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [1:0]  cmd_stb;
    logic [15:0] cmd_byte;
    logic [7:0]  mode_in = 8'h0C;
    logic        mode_wr;
    logic [7:0]  mode_wdata;
    logic [1:0]  eng_active = '0, eng_err_set = '0, eng_irq_set = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  m_cmd [2];
    logic [7:0]  m_stat[2];
    logic [7:0]  m_tim [2];
    logic [31:0] m_ptr [2];
    logic        m_stb [2];

    always #10 clk = ~clk;

    bmw_window #(.NUM_CH(2), .TIM_RST(STRAP)) i_bmw_window (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .mode_in(mode_in),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .eng_active(eng_active),
        .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set)
    );

    // Expected register state, derived from the requirement text
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_cmd[c] = 8'h00; m_stat[c] = 8'h00; m_ptr[c] = 32'h0; m_stb[c] = 1'b0;
                m_tim[c] = STRAP[c*8 +: 8];
            end else begin
                logic hit, bytew;
                logic [7:0] ns;
                hit   = io_wr && (io_addr[3] == c[0]);
                bytew = hit && !io_addr[2] && io_size == 2'd0;
                m_stb[c] = bytew && io_addr[1:0] == 2'd0;
                if (m_stb[c]) m_cmd[c] = io_wdata[7:0];
                ns = 8'h00;
                ns[0] = eng_active[c];
                ns[1] = eng_err_set[c] | (m_stat[c][1] & !(bytew && io_addr[1:0] == 2'd2 && io_wdata[1]));
                ns[2] = eng_irq_set[c] | (m_stat[c][2] & !(bytew && io_addr[1:0] == 2'd2 && io_wdata[2]));
                ns[6:5] = (bytew && io_addr[1:0] == 2'd2) ? io_wdata[6:5] : m_stat[c][6:5];
                m_stat[c] = ns;
                if (bytew && io_addr[1:0] == 2'd3) m_tim[c] = io_wdata[7:0];
                if (hit && io_addr[2:0] == 3'd4 && io_size == 2'd2) m_ptr[c] = {io_wdata[31:2], 2'b00};
            end
        end
    end

    function automatic logic [31:0] ones_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
        int c;
        c = int'(a[3]);
        if (!a[2] && sz == 2'd0) begin
            case (a[1:0])
                2'd0: return {24'h0, m_cmd[c]};
                2'd1: return {24'h0, mode_in};
                2'd2: return {24'h0, m_stat[c]};
                default: return {24'h0, m_tim[c]};
            endcase
        end
        if (a[2:0] == 3'd4 && sz == 2'd2) return m_ptr[c];
        return ones_of(sz);
    endfunction

    function automatic string tag_of(input logic [3:0] a, input logic [1:0] sz);
        if (a[2]) return "R9";
        if (sz != 2'd0) return "R7";
        case (a[1:0])
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4/R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_strobes();
        for (int c = 0; c < 2; c++) begin
            chk(cmd_stb[c] == m_stb[c], "R2 strobe", {31'h0, cmd_stb[c]}, {31'h0, m_stb[c]});
            if (m_stb[c]) chk(cmd_byte[c*8 +: 8] == m_cmd[c], "R2 byte",
                              {24'h0, cmd_byte[c*8 +: 8]}, {24'h0, m_cmd[c]});
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [1:0] act, input logic [1:0] err,
                        input logic [1:0] irq, input string tag);
        logic ewr;
        @(negedge clk);
        check_strobes();
        io_rd = rd; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
        eng_active = act; eng_err_set = err; eng_irq_set = irq;
        #2;
        if (rd) chk(io_rdata == exp_read(a, sz), (tag == "") ? tag_of(a, sz) : tag,
                    io_rdata, exp_read(a, sz));
        ewr = wr && sz == 2'd0 && a[2:0] == 3'd1;
        chk(mode_wr == ewr, (sz != 2'd0) ? "R8 mode_wr" : "R3 mode_wr", {31'h0, mode_wr}, {31'h0, ewr});
        if (ewr) chk(mode_wdata == ((mode_in & 8'hCF) | (wd[7:0] & 8'h30)), "R3 merge",
                     {24'h0, mode_wdata}, {24'h0, (mode_in & 8'hCF) | (wd[7:0] & 8'h30)});
    endtask

    task automatic rd_(input logic [3:0] a, input logic [1:0] sz, input string tag);
        step(1'b1, 1'b0, a, sz, 32'h0, eng_active, 2'b00, 2'b00, tag);
    endtask

    task automatic wr_(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        step(1'b0, 1'b1, a, sz, d, eng_active, 2'b00, 2'b00, "");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values on every byte register and pointer
        for (int a = 0; a < 16; a++) begin
            if (a[2:0] != 3'd1) rd_(4'(a), (a[2]) ? 2'd2 : 2'd0, "R1");
        end
        // R2 command strobes per channel
        wr_(4'h0, 2'd0, 32'hA5); wr_(4'h8, 2'd0, 32'h3C);
        rd_(4'h0, 2'd0, "R2"); rd_(4'h8, 2'd0, "R2");
        // R3 mode alias
        mode_in = 8'h0C; wr_(4'h9, 2'd0, 32'hFF); rd_(4'h1, 2'd0, "R3");
        // R4 status merge after engine sets
        step(1'b0, 1'b0, 4'h0, 2'd0, 0, 2'b01, 2'b01, 2'b01, "");
        wr_(4'h2, 2'd0, 32'hFF); rd_(4'h2, 2'd0, "R4");
        // R5 set beats same-cycle clear
        step(1'b0, 1'b1, 4'hA, 2'd0, 32'h06, 2'b00, 2'b10, 2'b10, "");
        rd_(4'hA, 2'd0, "R5");
        // R6 timing per channel
        wr_(4'h3, 2'd0, 32'h81); wr_(4'hB, 2'd0, 32'h7E);
        rd_(4'h3, 2'd0, "R6"); rd_(4'hB, 2'd0, "R6");
        // R8 wide writes ignored
        wr_(4'h3, 2'd1, 32'hFFFF); wr_(4'h8, 2'd2, 32'h1234_5678); wr_(4'h2, 2'd3, 32'hFF);
        rd_(4'h3, 2'd0, "R8"); rd_(4'h8, 2'd0, "R8"); rd_(4'h2, 2'd0, "R8");
        // R9 pointer
        wr_(4'h4, 2'd2, 32'hDEAD_BEEF); wr_(4'hC, 2'd0, 32'h55); wr_(4'h5, 2'd2, 32'h1111_1111);
        rd_(4'h4, 2'd2, "R9"); rd_(4'hC, 2'd0, "R9"); rd_(4'h6, 2'd1, "R9");
        // R7 rejected control reads
        rd_(4'h1, 2'd1, "R7"); rd_(4'h9, 2'd2, "R7"); rd_(4'h2, 2'd3, "R7");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:29] == 3'd0) mode_in = 8'($urandom);
            step(r[0], !r[0] && r[1], 4'($urandom), (r[4:2] < 3'd5) ? 2'd0 : 2'(r[6:5]),
                 $urandom, 2'(r[8:7]), (r[12:9] == 4'd0) ? 2'(r[14:13]) : 2'b00,
                 (r[18:15] == 4'd0) ? 2'(r[20:19]) : 2'b00, "");
        end
        step(1'b0, 1'b0, 4'h0, 2'd0, 0, 2'b00, 2'b00, 2'b00, "");
        step(1'b0, 1'b0, 4'h0, 2'd0, 0, 2'b00, 2'b00, 2'b00, "");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule